// File: doc/BRIEF.md
# Interrupt Pin Service Engine

This block is the request-handling core of an I/O interrupt controller with 24 input pins. Request events arrive one at a time as a pin index plus a level. Each pin's behaviour comes from its 64-bit redirection entry, which a separate register file owns and presents on a flat side bus. A pin is either edge or level triggered, and either masked or unmasked. The engine keeps one pending bit per pin. For level pins it also keeps the remote-IRR flag and hands that flag back to the register file so that reads of the entry can show it.

A continuous scanner looks for pending pins that may be serviced and picks the lowest-numbered one. It turns that pin's entry into a message-signalled interrupt: a 32-bit address and a 32-bit data word, presented on a valid/ready output. An edge pin drops its pending bit when its message is issued. A level pin instead raises remote-IRR, and while remote-IRR is up its requests coalesce into no further messages. A broadcast end-of-interrupt carrying a vector clears remote-IRR on every pin whose entry holds that vector. If such a pin is still pending and unmasked, it is serviced again.

Top module: `irq_pin_engine`

## Requirements
- R1: Request index 0 acts on pin 2. Indices 1 to 23 act on the pin of the same number. An index of 24 or more changes nothing.
- R2: On a level pin (entry bit 15 = 1), a request with level 1 sets the pending bit and a request with level 0 clears it, whether or not the pin is masked.
- R3: On an edge pin (entry bit 15 = 0), a level-1 request sets the pending bit only when the mask (entry bit 16) is 0. A request on a masked edge pin is discarded, and unmasking the pin later produces no message. A level-0 request has no effect on an edge pin.
- R4: Issuing an edge pin's message clears its pending bit, so one request yields exactly one message.
- R5: Issuing a level pin's message sets that pin's remote_irr bit. While that bit is set, the pin issues no further message, whatever requests arrive.
- R6: An end-of-interrupt with vector V clears remote_irr on every pin whose entry bits [7:0] equal V. A pin that is then still pending and unmasked issues its message again. Pins with other vectors keep remote_irr.
- R7: remote_irr is 0 for every pin whose entry is edge triggered. Switching a pin's entry to edge clears its remote_irr on the next cycle.
- R8: The message address is 0xFEE00000 with the destination ID (entry bits [55:48]) in address bits [19:12] and the destination mode (entry bit 11) in address bit 2. The message data holds the vector (entry [7:0]) in bits [7:0], the delivery mode (entry [10:8]) in bits [10:8] and the trigger mode in bit 15. All other bits are 0.
- R9: When several pins are eligible at once, messages leave in ascending pin order, one per accepted handshake.
- R10: While msg_valid is high and msg_ready is low, msg_valid, msg_addr and msg_data hold their values.
- R11: Reset clears all pending and remote-IRR state and drives msg_valid low.
- R12: A pending pin that is masked issues no message. Once it is unmasked, a level pin that is still pending issues one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request event strobe |
| req_idx | input | 5 | Request input index |
| req_level | input | 1 | Request level |
| eoi_valid | input | 1 | Broadcast end-of-interrupt strobe |
| eoi_vector | input | 8 | Vector carried by the end-of-interrupt |
| rte_flat | input | 1536 | All 24 redirection entries, 64 bits each, pin 0 in the low bits |
| remote_irr | output | 24 | Remote-IRR flag per pin, returned to the register file |
| msg_valid | output | 1 | Message available |
| msg_ready | input | 1 | Consumer accepts the message |
| msg_addr | output | 32 | Message address |
| msg_data | output | 32 | Message data |

## Verification
The bench builds the engine with its defaults: 24 pins and a 5-bit request index. This leaves indices 24 to 31 available to exercise the out-of-range case, and makes index 0 the redirect onto pin 2. In the random phase, vectors are drawn from only four values, so a single end-of-interrupt often releases several pins at once. Entries are rewritten while requests are in flight, which covers the edge/level switch and unmasking of pins that are already pending.

// File: rtl/irqe_pkg.sv
package irqe_pkg;

  localparam int RTE_W     = 64;
  localparam int VEC_W     = 8;
  localparam int VEC_LSB   = 0;
  localparam int DLV_LSB   = 8;
  localparam int DMODE_BIT = 11;
  localparam int TRIG_BIT  = 15;
  localparam int MASK_BIT  = 16;
  localparam int DEST_LSB  = 48;
  localparam logic [11:0] MSG_HI = 12'hFEE;

  typedef struct packed {
    logic [VEC_W-1:0] vec;
    logic [2:0]       dlv;
    logic             dmode;
    logic             level;
    logic             masked;
    logic [7:0]       dest;
  } rte_t;

  function automatic rte_t rte_decode(input logic [RTE_W-1:0] raw);
    rte_t e;
    e.vec    = raw[VEC_LSB +: VEC_W];
    e.dlv    = raw[DLV_LSB +: 3];
    e.dmode  = raw[DMODE_BIT];
    e.level  = raw[TRIG_BIT];
    e.masked = raw[MASK_BIT];
    e.dest   = raw[DEST_LSB +: 8];
    return e;
  endfunction

  function automatic logic [31:0] msg_addr_of(input rte_t e);
    return {MSG_HI, e.dest, 9'd0, e.dmode, 2'd0};
  endfunction

  function automatic logic [31:0] msg_data_of(input rte_t e);
    return {16'd0, e.level, 4'd0, e.dlv, e.vec};
  endfunction

endpackage

// File: rtl/irqe_pend.sv
module irqe_pend #(
  parameter int NUM_PINS = 24
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [NUM_PINS-1:0] ev_hot,
  input  logic                ev_lvl,
  input  logic [NUM_PINS-1:0] level_v,
  input  logic [NUM_PINS-1:0] mask_v,
  input  logic [NUM_PINS-1:0] clr_v,
  output logic [NUM_PINS-1:0] irr
);

  for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
    logic nxt;
    always_comb begin
      nxt = irr[p] & ~clr_v[p];
      if (ev_hot[p]) begin
        if (level_v[p])                nxt = ev_lvl;
        else if (ev_lvl && !mask_v[p]) nxt = 1'b1;
      end
    end
    always_ff @(posedge clk) begin
      if (rst) irr[p] <= 1'b0;
      else     irr[p] <= nxt;
    end
  end

endmodule

// File: rtl/irqe_rirr.sv
module irqe_rirr #(
  parameter int NUM_PINS = 24,
  parameter int VEC_W    = 8
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic [NUM_PINS-1:0]       set_v,
  input  logic                      eoi_valid,
  input  logic [VEC_W-1:0]          eoi_vector,
  input  logic [NUM_PINS*VEC_W-1:0] vec_flat,
  input  logic [NUM_PINS-1:0]       level_v,
  output logic [NUM_PINS-1:0]       rirr
);

  for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
    logic hit;
    assign hit = eoi_valid && (vec_flat[p*VEC_W +: VEC_W] == eoi_vector);
    always_ff @(posedge clk) begin
      if (rst) rirr[p] <= 1'b0;
      else     rirr[p] <= ((rirr[p] & ~hit) | set_v[p]) & level_v[p];
    end
  end

endmodule

// File: rtl/irqe_pick.sv
module irqe_pick #(
  parameter int NUM_PINS = 24,
  localparam int PIN_W   = $clog2(NUM_PINS)
) (
  input  logic [NUM_PINS-1:0] elig,
  output logic                found,
  output logic [NUM_PINS-1:0] onehot,
  output logic [PIN_W-1:0]    idx
);

  assign found  = |elig;
  assign onehot = elig & (~elig + NUM_PINS'(1));

  always_comb begin
    idx = '0;
    for (int p = NUM_PINS - 1; p >= 0; p--) begin
      if (elig[p]) idx = PIN_W'(p);
    end
  end

endmodule

// File: rtl/irqe_msg_out.sv
module irqe_msg_out (
  input  logic        clk,
  input  logic        rst,
  input  logic        cand,
  input  logic [31:0] ld_addr,
  input  logic [31:0] ld_data,
  input  logic        msg_ready,
  output logic        take,
  output logic        msg_valid,
  output logic [31:0] msg_addr,
  output logic [31:0] msg_data
);

  assign take = cand && (!msg_valid || msg_ready);

  always_ff @(posedge clk) begin
    if (rst) begin
      msg_valid <= 1'b0;
      msg_addr  <= '0;
      msg_data  <= '0;
    end else if (take) begin
      msg_valid <= 1'b1;
      msg_addr  <= ld_addr;
      msg_data  <= ld_data;
    end else if (msg_ready) begin
      msg_valid <= 1'b0;
    end
  end

endmodule

// File: rtl/irq_pin_engine.sv
module irq_pin_engine #(
  parameter int NUM_PINS = 24,
  parameter int REQ_W    = 5,
  localparam int RTE_W   = irqe_pkg::RTE_W,
  localparam int VEC_W   = irqe_pkg::VEC_W,
  localparam int PIN_W   = $clog2(NUM_PINS)
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      req_valid,
  input  logic [REQ_W-1:0]          req_idx,
  input  logic                      req_level,
  input  logic                      eoi_valid,
  input  logic [VEC_W-1:0]          eoi_vector,
  input  logic [NUM_PINS*RTE_W-1:0] rte_flat,
  output logic [NUM_PINS-1:0]       remote_irr,
  output logic                      msg_valid,
  input  logic                      msg_ready,
  output logic [31:0]               msg_addr,
  output logic [31:0]               msg_data
);
  import irqe_pkg::*;

  rte_t                      dec [NUM_PINS];
  logic [NUM_PINS-1:0]       level_v, mask_v, elig, ev_hot, irr;
  logic [NUM_PINS*VEC_W-1:0] vec_flat;
  logic [REQ_W-1:0]          ev_pin;
  logic                      ev_ok;
  logic                      found, take;
  logic [NUM_PINS-1:0]       onehot, set_v, clr_v;
  logic [PIN_W-1:0]          pick_idx;
  rte_t                      sel;

  // input 0 is steered onto pin 2
  assign ev_pin = (req_idx == '0) ? REQ_W'(2) : req_idx;
  assign ev_ok  = req_valid && (int'(ev_pin) < NUM_PINS);

  for (genvar p = 0; p < NUM_PINS; p++) begin : g_dec
    assign dec[p]                  = rte_decode(rte_flat[p*RTE_W +: RTE_W]);
    assign level_v[p]              = dec[p].level;
    assign mask_v[p]               = dec[p].masked;
    assign vec_flat[p*VEC_W +: VEC_W] = dec[p].vec;
    assign elig[p]   = irr[p] && !mask_v[p] && !(level_v[p] && remote_irr[p]);
    assign ev_hot[p] = ev_ok && (int'(ev_pin) == p);
  end

  irqe_pick #(.NUM_PINS(NUM_PINS)) u_pick (
    .elig   (elig),
    .found  (found),
    .onehot (onehot),
    .idx    (pick_idx)
  );

  assign sel   = dec[pick_idx];
  assign set_v = take ? (onehot & level_v)  : '0;
  assign clr_v = take ? (onehot & ~level_v) : '0;

  irqe_pend #(.NUM_PINS(NUM_PINS)) u_pend (
    .clk     (clk),
    .rst     (rst),
    .ev_hot  (ev_hot),
    .ev_lvl  (req_level),
    .level_v (level_v),
    .mask_v  (mask_v),
    .clr_v   (clr_v),
    .irr     (irr)
  );

  irqe_rirr #(.NUM_PINS(NUM_PINS), .VEC_W(VEC_W)) u_rirr (
    .clk        (clk),
    .rst        (rst),
    .set_v      (set_v),
    .eoi_valid  (eoi_valid),
    .eoi_vector (eoi_vector),
    .vec_flat   (vec_flat),
    .level_v    (level_v),
    .rirr       (remote_irr)
  );

  irqe_msg_out u_out (
    .clk       (clk),
    .rst       (rst),
    .cand      (found),
    .ld_addr   (msg_addr_of(sel)),
    .ld_data   (msg_data_of(sel)),
    .msg_ready (msg_ready),
    .take      (take),
    .msg_valid (msg_valid),
    .msg_addr  (msg_addr),
    .msg_data  (msg_data)
  );

endmodule

// File: rtl/irqe_checker.sv
module irqe_checker #(
  parameter int NUM_PINS = 24
) (
  input logic                   clk,
  input logic                   rst,
  input logic [NUM_PINS*64-1:0] rte_flat,
  input logic [NUM_PINS-1:0]    remote_irr,
  input logic                   msg_valid,
  input logic                   msg_ready,
  input logic [31:0]            msg_addr,
  input logic [31:0]            msg_data
);

  logic [NUM_PINS-1:0] lvl;
  for (genvar p = 0; p < NUM_PINS; p++) begin : g_lvl
    assign lvl[p] = rte_flat[p*64 + 15];
  end

  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (rst)
    msg_valid && !msg_ready |=> msg_valid && $stable(msg_addr) && $stable(msg_data)); // R10

  AST_ADDR_SHAPE: assert property (@(posedge clk) disable iff (rst)
    msg_valid |-> msg_addr[31:20] == 12'hFEE && msg_addr[11:3] == '0 && msg_addr[1:0] == '0); // R8

  AST_DATA_SHAPE: assert property (@(posedge clk) disable iff (rst)
    msg_valid |-> msg_data[31:16] == '0 && msg_data[14:11] == '0); // R8

  AST_EDGE_NO_RIRR: assert property (@(posedge clk) disable iff (rst)
    msg_ready || !msg_ready |=> (remote_irr & ~$past(lvl)) == '0); // R7

  AST_RIRR_WITH_MSG: assert property (@(posedge clk) disable iff (rst)
    (|(remote_irr & ~$past(remote_irr))) |-> msg_valid && msg_data[15]); // R5

  AST_ONE_PER_ISSUE: assert property (@(posedge clk) disable iff (rst)
    $countones(remote_irr & ~$past(remote_irr)) <= 1); // R9

endmodule

bind irq_pin_engine irqe_checker #(.NUM_PINS(NUM_PINS)) u_irqe_chk (
  .clk        (clk),
  .rst        (rst),
  .rte_flat   (rte_flat),
  .remote_irr (remote_irr),
  .msg_valid  (msg_valid),
  .msg_ready  (msg_ready),
  .msg_addr   (msg_addr),
  .msg_data   (msg_data)
);

// File: tb/irq_pin_engine_bench.sv
`timescale 1ns/1ps
module irq_pin_engine_bench;
  localparam int NP = 24;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic req_valid = 1'b0, req_level = 1'b0, eoi_valid = 1'b0, msg_ready = 1'b1;
  logic [4:0]  req_idx = '0;
  logic [7:0]  eoi_vector = '0;
  logic [63:0] rte [NP];
  logic [NP*64-1:0] rte_flat;
  logic [NP-1:0] remote_irr;
  logic msg_valid;
  logic [31:0] msg_addr, msg_data;

  always #2.5 clk = ~clk;

  for (genvar p = 0; p < NP; p++) begin : g_pack
    assign rte_flat[p*64 +: 64] = rte[p];
  end

  irq_pin_engine u_irq_pin_engine (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_idx(req_idx),
    .req_level(req_level), .eoi_valid(eoi_valid), .eoi_vector(eoi_vector),
    .rte_flat(rte_flat), .remote_irr(remote_irr), .msg_valid(msg_valid),
    .msg_ready(msg_ready), .msg_addr(msg_addr), .msg_data(msg_data)
  );

  int checks = 0, errors = 0;
  logic [63:0] q [$];

  task automatic chk(input bit ok, input string rq, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", rq, act, exp);
    end
  endtask

  function automatic logic [63:0] mk(input logic [7:0] v, input logic [2:0] dl, input logic dm,
                                     input logic lv, input logic ms, input logic [7:0] d);
    logic [63:0] e = '0;
    e[7:0] = v; e[10:8] = dl; e[11] = dm; e[15] = lv; e[16] = ms; e[55:48] = d;
    return e;
  endfunction
  function automatic logic [31:0] ex_addr(input logic [63:0] e);
    return {12'hFEE, e[55:48], 9'd0, e[11], 2'd0};
  endfunction
  function automatic logic [31:0] ex_data(input logic [63:0] e);
    return {16'd0, e[15], 4'd0, e[10:8], e[7:0]};
  endfunction

  // reference model built from the requirements
  logic [NP-1:0] m_irr, m_rirr, ni, nr;
  logic m_v; logic [31:0] m_a, m_d;
  int m_c, mp; bit m_fire;
  always @(posedge clk) begin
    if (rst) begin
      m_irr <= '0; m_rirr <= '0; m_v <= 1'b0; m_a <= '0; m_d <= '0;
    end else begin
      m_c = -1;
      for (int p = 0; p < NP; p++)
        if (m_c < 0 && m_irr[p] && !rte[p][16] && !(rte[p][15] && m_rirr[p])) m_c = p;
      m_fire = (m_c >= 0) && (!m_v || msg_ready);
      ni = m_irr; nr = m_rirr;
      for (int p = 0; p < NP; p++)
        if (eoi_valid && rte[p][7:0] == eoi_vector) nr[p] = 1'b0;
      if (m_fire) begin
        if (rte[m_c][15]) nr[m_c] = 1'b1; else ni[m_c] = 1'b0;
      end
      for (int p = 0; p < NP; p++) if (!rte[p][15]) nr[p] = 1'b0;
      if (req_valid) begin
        mp = (req_idx == 0) ? 2 : int'(req_idx);
        if (mp < NP) begin
          if (rte[mp][15]) ni[mp] = req_level;
          else if (req_level && !rte[mp][16]) ni[mp] = 1'b1;
        end
      end
      m_irr <= ni; m_rirr <= nr;
      if (m_fire) begin
        m_v <= 1'b1; m_a <= ex_addr(rte[m_c]); m_d <= ex_data(rte[m_c]);
      end else if (msg_ready) m_v <= 1'b0;
    end
  end

  // monitor and model comparison, away from the active edge
  always @(negedge clk) begin
    if (!rst) begin
      if (msg_valid && msg_ready) q.push_back({msg_addr, msg_data});
      chk(msg_valid == m_v, "R9 msg_valid vs model", 64'(msg_valid), 64'(m_v));
      if (msg_valid && m_v)
        chk({msg_addr, msg_data} == {m_a, m_d}, "R8 message vs model",
            {msg_addr, msg_data}, {m_a, m_d});
      chk(remote_irr == m_rirr, "R5 remote_irr vs model", 64'(remote_irr), 64'(m_rirr));
    end
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask
  task automatic req(input int idx, input logic lv);
    req_valid = 1'b1; req_idx = 5'(idx); req_level = lv;
    @(negedge clk); req_valid = 1'b0;
  endtask
  task automatic eoi(input logic [7:0] v);
    eoi_valid = 1'b1; eoi_vector = v;
    @(negedge clk); eoi_valid = 1'b0;
  endtask

  bit done = 0;
  initial begin
    #(5.0 * 150000);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  int n0;
  logic [63:0] held;
  initial begin
    void'($urandom(32'd4242));
    for (int p = 0; p < NP; p++) rte[p] = mk(8'h00, 3'd0, 1'b0, 1'b0, 1'b1, 8'h00);
    tick(3);
    chk(msg_valid == 1'b0, "R11 msg_valid in reset", 64'(msg_valid), 0);
    chk(remote_irr == '0, "R11 remote_irr in reset", 64'(remote_irr), 0);
    rst = 1'b0;
    tick(2);

    // R1 / R8 / R4: index 0 lands on pin 2
    rte[2] = mk(8'h32, 3'd0, 1'b1, 1'b0, 1'b0, 8'h05);
    q.delete(); req(0, 1'b1); tick(4);
    chk(q.size() == 1, "R4 one message per edge request", 64'(q.size()), 1);
    if (q.size() > 0) chk(q[0] == {32'hFEE05004, 32'h00000032}, "R1 R8 pin2 message", q[0],
                          {32'hFEE05004, 32'h00000032});

    // R1: out-of-range indices
    rte[23] = mk(8'h33, 3'd0, 1'b0, 1'b0, 1'b0, 8'h01);
    q.delete(); req(24, 1'b1); req(31, 1'b1); tick(4);
    chk(q.size() == 0, "R1 index >= 24 ignored", 64'(q.size()), 0);

    // R3: masked edge discarded, level 0 ignored
    rte[5] = mk(8'h50, 3'd0, 1'b0, 1'b0, 1'b1, 8'h01);
    q.delete(); req(5, 1'b1); tick(2);
    rte[5][16] = 1'b0; tick(4);
    chk(q.size() == 0, "R3 masked edge request dropped", 64'(q.size()), 0);
    req(5, 1'b0); tick(4);
    chk(q.size() == 0, "R3 level 0 on edge pin", 64'(q.size()), 0);
    req(5, 1'b1); tick(4);
    chk(q.size() == 1, "R4 edge pin single message", 64'(q.size()), 1);
    if (q.size() > 0) chk(q[0] == {32'hFEE01000, 32'h00000050}, "R8 edge message", q[0],
                          {32'hFEE01000, 32'h00000050});

    // R5 / R6 / R2: level pin with remote-IRR
    rte[7] = mk(8'h41, 3'd1, 1'b0, 1'b1, 1'b0, 8'h22);
    q.delete(); req(7, 1'b1); tick(4);
    chk(q.size() == 1, "R5 level message issued", 64'(q.size()), 1);
    if (q.size() > 0) chk(q[0] == {32'hFEE22000, 32'h00008141}, "R8 level message", q[0],
                          {32'hFEE22000, 32'h00008141});
    chk(remote_irr[7] == 1'b1, "R5 remote_irr set", 64'(remote_irr[7]), 1);
    req(7, 1'b0); req(7, 1'b1); tick(4);
    chk(q.size() == 1, "R5 coalesced while remote_irr", 64'(q.size()), 1);
    eoi(8'h40); tick(4);
    chk(remote_irr[7] == 1'b1 && q.size() == 1, "R6 other vector keeps remote_irr",
        64'(remote_irr[7]), 1);
    eoi(8'h41); tick(4);
    chk(q.size() == 2, "R6 reissue after matching eoi", 64'(q.size()), 2);
    req(7, 1'b0); eoi(8'h41); tick(4);
    chk(remote_irr[7] == 1'b0, "R6 eoi clears remote_irr", 64'(remote_irr[7]), 0);
    chk(q.size() == 2, "R2 deassert cleared pending", 64'(q.size()), 2);

    // R7: switching to edge drops remote_irr
    req(7, 1'b1); tick(4);
    chk(remote_irr[7] == 1'b1, "R7 precondition remote_irr", 64'(remote_irr[7]), 1);
    rte[7][15] = 1'b0; tick(2);
    chk(remote_irr[7] == 1'b0, "R7 edge entry clears remote_irr", 64'(remote_irr[7]), 0);
    rte[7][16] = 1'b1; tick(3);

    // R12 / R2: masked pending level pin
    rte[9] = mk(8'h60, 3'd0, 1'b0, 1'b1, 1'b1, 8'h09);
    n0 = q.size(); req(9, 1'b1); tick(4);
    chk(q.size() == n0, "R12 masked pending not sent", 64'(q.size()), 64'(n0));
    rte[9][16] = 1'b0; tick(4);
    chk(q.size() == n0 + 1, "R12 sent after unmask", 64'(q.size()), 64'(n0 + 1));
    rte[9][16] = 1'b1; req(9, 1'b0); eoi(8'h60); rte[9][16] = 1'b0; tick(4);
    chk(q.size() == n0 + 1, "R2 masked deassert cleared pending", 64'(q.size()), 64'(n0 + 1));

    // R9 / R10: ordering and stall
    rte[4]  = mk(8'h44, 3'd0, 1'b0, 1'b1, 1'b1, 8'h04);
    rte[10] = mk(8'h4A, 3'd0, 1'b0, 1'b1, 1'b1, 8'h0A);
    rte[20] = mk(8'h54, 3'd0, 1'b0, 1'b1, 1'b1, 8'h14);
    req(20, 1'b1); req(4, 1'b1); req(10, 1'b1);
    msg_ready = 1'b0;
    rte[4][16] = 1'b0; rte[10][16] = 1'b0; rte[20][16] = 1'b0;
    q.delete(); tick(3);
    chk(msg_valid && msg_data[7:0] == 8'h44, "R9 lowest pin first", 64'(msg_data), 64'h8044);
    held = {msg_addr, msg_data}; tick(3);
    chk(msg_valid && {msg_addr, msg_data} == held, "R10 stalled message holds",
        {msg_addr, msg_data}, held);
    msg_ready = 1'b1; tick(5);
    chk(q.size() == 3, "R9 three messages", 64'(q.size()), 3);
    if (q.size() == 3)
      chk(q[0][7:0] == 8'h44 && q[1][7:0] == 8'h4A && q[2][7:0] == 8'h54,
          "R9 ascending order", {q[0][7:0], q[1][7:0], q[2][7:0]}, 64'h444A54);

    // random phase against the model
    for (int p = 0; p < NP; p++)
      rte[p] = mk(8'h40 + 8'($urandom % 4), 3'($urandom), 1'($urandom), 1'($urandom),
                  1'($urandom % 4 == 0), 8'($urandom));
    for (int i = 0; i < 4000; i++) begin
      msg_ready  = ($urandom % 4) != 0;
      req_valid  = ($urandom % 3) == 0;
      req_idx    = 5'($urandom);
      req_level  = 1'($urandom);
      eoi_valid  = ($urandom % 6) == 0;
      eoi_vector = 8'h40 + 8'($urandom % 4);
      if ($urandom % 8 == 0) begin
        automatic int k = int'($urandom % NP);
        rte[k] = mk(8'h40 + 8'($urandom % 4), 3'($urandom), 1'($urandom), 1'($urandom),
                    1'($urandom % 4 == 0), 8'($urandom));
        rte[k][14] = 1'($urandom);
      end
      @(negedge clk);
    end
    req_valid = 1'b0; eoi_valid = 1'b0; msg_ready = 1'b1;
    tick(4);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule